// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block sits between an on-chip requester and an external byte-wide asynchronous static RAM. Each request is one read or one write of a single byte. The controller turns it into a timed sequence on the memory's address lines, on a split data bus (drive value, drive enable, sampled input) and on three active-low strobes: select, read-output enable and write strobe. The length of every phase is a whole number of clock cycles. Each length is worked out at elaboration from the memory's nanosecond minimums and the clock period, rounded up, and is never less than one cycle.

After reset the controller waits for the memory's power-up interval before it accepts anything. Between accesses it deselects the memory, so the part stays in its low-power standby state. Writes keep the read-output enable high for their whole length, so the memory never drives the bus while a write is in progress. When a write follows a read, a turnaround phase lets the memory's output drivers switch off before the controller drives data.

Top module: `sram_ctl`

## Requirements
- R1: After reset is released, `req_ready` stays low for PWRUP_N clock edges (PWRUP_N = ceil(T_PWRUP_PS / CLK_PS), 50 with the bench parameters). It is high after the PWRUP_N-th edge. The memory stays deselected for that whole time.
- R2: A read drives the address with `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_N cycles. RD_N = ceil(max(tAA, tDOE) / clock), which is 3 at 250 MHz. On the edge that ends the last of these cycles, `mem_din` is captured into `rd_data` and `rd_valid` is raised for one cycle.
- R3: A write holds `mem_ce_n`=0 and `mem_oe_n`=1. It then drives data with `mem_doe`=1 and `mem_we_n`=0 for PULSE_N cycles, which is 2 at 250 MHz. This is followed by one end cycle with `mem_we_n`=1, `mem_doe`=0, `mem_ce_n`=0, the address unchanged and `wr_ack`=1.
- R4: The data driver is released on the same edge that raises `mem_we_n`. `mem_doe` is never high while `mem_oe_n` is low.
- R5: A write whose previous access was a read first spends TURN_N cycles with `mem_ce_n`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_doe`=0 before its strobe pulse. TURN_N is 2 at 250 MHz. A write whose previous access was a write has no such phase.
- R6: When idle, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1 and `mem_doe` is 0. `req_ready` is high only in the idle state after start-up.
- R7: A request presented while `req_ready` is low is not taken: it starts no access, raises no acknowledge and changes no memory byte.
- R8: PULSE_N is the largest of ceil(tPWE), ceil(tSD) and ceil(tWC) - 1 in cycles, so that the strobe pulse plus the end cycle spans the write cycle time. The address stays constant while the memory is selected.
- R9: During reset and right after it, all strobes are high, `mem_doe`, `rd_valid` and `wr_ack` are 0, and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle and past start-up; a request is taken on this cycle |
| wr_ack | output | 1 | One-cycle write-complete pulse |
| rd_valid | output | 1 | One-cycle read-complete pulse |
| rd_data | output | 8 | Byte captured by the last read |
| mem_addr | output | 17 | Memory address |
| mem_dout | output | 8 | Data driven toward the memory |
| mem_doe | output | 1 | Enable of the data driver |
| mem_din | input | 8 | Data sampled from the memory pins |
| mem_ce_n | output | 1 | Active-low select |
| mem_oe_n | output | 1 | Active-low read-output enable |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The embedded properties watch, on every cycle, the rules that keep the bus safe. The write strobe only falls while the memory is selected with output enable high. The driver never overlaps the read-output enable, and it is released on the edge where the strobe rises. The address holds while the memory is selected, and the strobe pulse is never shorter than PULSE_N. The bench's directed scenarios cover what a per-cycle rule cannot show: the exact cycle counts of each phase, the presence or absence of the turnaround depending on the previous access, the data returned after varied write patterns, the start-up wait, and requests that are dropped while the controller is busy.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_TURN = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WEND = 3'd4
  } ctl_state_t;

  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction
endpackage

// File: rtl/sram_pwrup_wait.sv
module sram_pwrup_wait #(
  parameter int WAIT_N = 25000
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int CW = $clog2(WAIT_N + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(WAIT_N - 1)) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_PS    = 4000,
  parameter int T_AA_PS   = 10000,
  parameter int T_DOE_PS  = 5000,
  parameter int T_PWE_PS  = 7000,
  parameter int T_SD_PS   = 5000,
  parameter int T_WC_PS   = 10000,
  parameter int T_HZ_PS   = 5000,
  parameter int T_PWRUP_PS = 100000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          wr_ack,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  input  logic [DW-1:0] mem_din,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);
  localparam int RD_N    = cyc_ceil((T_AA_PS > T_DOE_PS) ? T_AA_PS : T_DOE_PS, CLK_PS);
  localparam int PWE_N   = cyc_ceil(T_PWE_PS, CLK_PS);
  localparam int SD_N    = cyc_ceil(T_SD_PS, CLK_PS);
  localparam int WCM_N   = cyc_ceil(T_WC_PS, CLK_PS) - 1;
  localparam int PULSE_A = (PWE_N > SD_N) ? PWE_N : SD_N;
  localparam int PULSE_N = (PULSE_A > WCM_N) ? PULSE_A : WCM_N;
  localparam int TURN_N  = cyc_ceil(T_HZ_PS, CLK_PS);
  localparam int PWRUP_N = cyc_ceil(T_PWRUP_PS, CLK_PS);
  localparam int MAX_A   = (RD_N > PULSE_N) ? RD_N : PULSE_N;
  localparam int MAX_N   = (MAX_A > TURN_N) ? MAX_A : TURN_N;
  localparam int TW      = $clog2(MAX_N + 1);

  ctl_state_t    st, st_nx;
  logic          up_rdy;
  logic          t_load, t_done;
  logic [TW-1:0] t_val;
  logic [DW-1:0] wbuf, wbuf_nx;
  logic          prev_rd, prev_rd_nx;
  logic [AW-1:0] addr_nx;
  logic [DW-1:0] dout_nx, rdat_nx;
  logic          doe_nx, ce_nx, oe_nx, we_nx, ack_nx, rv_nx;
  logic          take;

  sram_pwrup_wait #(.WAIT_N(PWRUP_N)) u_wait (
    .clk(clk), .rst(rst), .ready(up_rdy)
  );

  sram_cycle_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  assign req_ready = up_rdy && (st == ST_IDLE);
  assign take      = req_ready && req_valid;

  always_comb begin
    st_nx      = st;
    t_load     = 1'b0;
    t_val      = '0;
    wbuf_nx    = wbuf;
    prev_rd_nx = prev_rd;
    addr_nx    = mem_addr;
    dout_nx    = mem_dout;
    rdat_nx    = rd_data;
    doe_nx     = mem_doe;
    ce_nx      = mem_ce_n;
    oe_nx      = mem_oe_n;
    we_nx      = mem_we_n;
    ack_nx     = 1'b0;
    rv_nx      = 1'b0;
    case (st)
      ST_IDLE: begin
        if (take) begin
          addr_nx = req_addr;
          ce_nx   = 1'b0;
          t_load  = 1'b1;
          if (!req_write) begin
            st_nx      = ST_READ;
            oe_nx      = 1'b0;
            t_val      = TW'(RD_N - 1);
            prev_rd_nx = 1'b1;
          end else begin
            wbuf_nx    = req_wdata;
            prev_rd_nx = 1'b0;
            if (prev_rd) begin
              st_nx = ST_TURN;
              t_val = TW'(TURN_N - 1);
            end else begin
              st_nx   = ST_WPULSE;
              we_nx   = 1'b0;
              doe_nx  = 1'b1;
              dout_nx = req_wdata;
              t_val   = TW'(PULSE_N - 1);
            end
          end
        end
      end
      ST_READ: begin
        if (t_done) begin
          rdat_nx = mem_din;
          rv_nx   = 1'b1;
          ce_nx   = 1'b1;
          oe_nx   = 1'b1;
          st_nx   = ST_IDLE;
        end
      end
      ST_TURN: begin
        if (t_done) begin
          st_nx   = ST_WPULSE;
          we_nx   = 1'b0;
          doe_nx  = 1'b1;
          dout_nx = wbuf;
          t_load  = 1'b1;
          t_val   = TW'(PULSE_N - 1);
        end
      end
      ST_WPULSE: begin
        if (t_done) begin
          st_nx  = ST_WEND;
          we_nx  = 1'b1;
          doe_nx = 1'b0;
          ack_nx = 1'b1;
        end
      end
      ST_WEND: begin
        ce_nx = 1'b1;
        st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      wbuf     <= '0;
      prev_rd  <= 1'b0;
      mem_addr <= '0;
      mem_dout <= '0;
      rd_data  <= '0;
      mem_doe  <= 1'b0;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      wr_ack   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      st       <= st_nx;
      wbuf     <= wbuf_nx;
      prev_rd  <= prev_rd_nx;
      mem_addr <= addr_nx;
      mem_dout <= dout_nx;
      rd_data  <= rdat_nx;
      mem_doe  <= doe_nx;
      mem_ce_n <= ce_nx;
      mem_oe_n <= oe_nx;
      mem_we_n <= we_nx;
      wr_ack   <= ack_nx;
      rd_valid <= rv_nx;
    end
  end

  // Strobe-low counter used only by the pulse-length property
  logic [TW:0] we_low_cnt;
  always_ff @(posedge clk) begin
    if (rst)            we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else                we_low_cnt <= '0;
  end

  // R1
  pwrup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !up_rdy |-> (mem_ce_n && !req_ready));
  // R3
  we_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));
  // R4
  no_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_doe && !mem_oe_n));
  // R4
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> !mem_doe);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_doe));
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt >= (TW+1)'(PULSE_N)));
  // R2
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_ack));
endmodule

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;
  localparam int AW = 17;
  localparam int DW = 8;
  // Expected phase lengths at a 4 ns clock, from the requirement formulas
  localparam int RD_N    = 3;   // ceil(10/4)
  localparam int PULSE_N = 2;   // max(ceil(7/4), ceil(5/4), ceil(10/4)-1)
  localparam int TURN_N  = 2;   // ceil(5/4)
  localparam int PWRUP_N = 50;  // 200 ns / 4 ns

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, wr_ack, rd_valid, mem_doe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [DW-1:0] rd_data, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] model [0:255];
  logic [7:0] expect_mem [0:255];

  always #2 clk = ~clk;

  sram_ctl #(.T_PWRUP_PS(200000)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .wr_ack(wr_ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n)
  );

  // Memory model: drives only when selected, output-enabled and not writing
  wire model_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_din = model_drv ? model[mem_addr[7:0]] : 8'hFF;
  always @(posedge clk)
    if (!mem_ce_n && !mem_we_n && mem_doe) model[mem_addr[7:0]] <= mem_dout;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && mem_doe && model_drv) chk(1'b0, "R4 bus clash", 1, 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic t_reset_startup();
    for (int i = 0; i < 256; i++) begin model[i] = 8'h00; expect_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_doe && !rd_valid && !wr_ack && !req_ready,
        "R9 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_doe, req_ready}, 5'b11100);
    rst = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00010; req_wdata = 8'h77;
    for (int i = 1; i < PWRUP_N; i++) begin
      @(negedge clk);
      // R7 request during start-up not taken
      if (!mem_ce_n || req_ready) chk(1'b0, "R7 startup request taken", i, 0);
    end
    chk(!req_ready, "R1 ready before wait", req_ready, 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready, "R1 ready after wait", req_ready, 1);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_doe, "R6 idle strobes",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_doe}, 4'b1110);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input logic turn);
    int bad = 0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    chk(req_ready, "R6 ready before write", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (turn) begin
      for (int i = 0; i < TURN_N; i++) begin
        if (!(!mem_ce_n && mem_oe_n && mem_we_n && !mem_doe && mem_addr == a)) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R5 turnaround phase", bad, 0);
    end
    bad = 0;
    for (int i = 0; i < PULSE_N; i++) begin
      if (!(!mem_ce_n && mem_oe_n && !mem_we_n && mem_doe && mem_dout == d && mem_addr == a)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R3 strobe pulse", bad, 0);
    chk(!mem_ce_n && mem_we_n && !mem_doe && wr_ack && mem_addr == a,
        "R3 write end cycle", {mem_ce_n, mem_we_n, mem_doe, wr_ack}, 4'b0101);
    @(negedge clk);
    chk(!wr_ack && mem_ce_n && req_ready, "R3 ack single cycle",
        {wr_ack, mem_ce_n, req_ready}, 3'b011);
    expect_mem[a[7:0]] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int bad = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < RD_N; i++) begin
      if (!(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_doe && mem_addr == a && !rd_valid)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R2 read strobes", bad, 0);
    chk(rd_valid && rd_data == expect_mem[a[7:0]], "R2 read data",
        {rd_valid, rd_data}, {1'b1, expect_mem[a[7:0]]});
    chk(mem_ce_n && mem_oe_n, "R6 deselect after read", {mem_ce_n, mem_oe_n}, 2'b11);
    @(negedge clk);
    chk(!rd_valid, "R2 valid single cycle", rd_valid, 0);
  endtask

  task automatic t_write_then_read();
    do_write(17'h00000, 8'hA5, 1'b0);
    do_write(17'h1FF01, 8'h5A, 1'b0); // R5 write after write: no turnaround
    do_read(17'h00000);
    do_read(17'h1FF01);
  endtask

  task automatic t_read_write_turn();
    do_write(17'h00022, 8'hFF, 1'b1); // R5 after read
    do_read(17'h00022);
    do_write(17'h00033, 8'h00, 1'b1);
    do_read(17'h00033);
    do_read(17'h00010); // R7: the start-up request left this byte at zero
  endtask

  task automatic t_busy_ignored();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00044;
    @(negedge clk);
    // R7 pulse a write while the read is in progress
    req_write = 1'b1; req_addr = 17'h00055; req_wdata = 8'h3C;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (RD_N + 3) @(negedge clk);
    chk(mem_ce_n && !wr_ack, "R7 busy request ignored", {mem_ce_n, wr_ack}, 2'b10);
    do_write(17'h00066, 8'hC3, 1'b1);
    do_read(17'h00055);
    do_read(17'h00066);
  endtask

  initial begin
    t_reset_startup();
    t_write_then_read();
    t_read_write_turn();
    t_busy_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule